// File: doc/BRIEF.md
# Comparator-Steered Stepping PWM Engine

This block drives the switch of a boost converter with a rectangular pulse train of fixed frequency. Each PWM frame is a fixed number of clocks long (50 by default, so a 2 MHz clock gives a 40 kHz drive). Inside the frame, a rise position and a fall position drive a set/reset style output register. The output goes high after the rise position and low after the fall position. The pulse width is the distance between the two positions.

An external output-voltage comparator supplies a single direction bit. An update fires once every `UPD_N` frames. On an update, a low direction bit moves the rise position one clock earlier, which widens the pulse. A high direction bit moves the fall position one clock earlier, which narrows the pulse. A freeze input stops the frame divider, so the width holds. When narrowing would make the two positions meet, the engine treats this as zero duty. It forces the output low, raises a halt flag, and restores its one-clock starting width. It stays halted until an update sees the direction bit low.

Top module: `pwm_step_gen`

## Requirements
- R1: A frame is exactly `PERIOD` clocks long. The pulse never wraps across a frame boundary, so the output is low in the first clock of every frame and the rise position always stays below the fall position.
- R2: During reset the output and the halt flag are low. In the first frame after reset the pulse is exactly one clock wide.
- R3: At an update with the synchronised direction bit low (0 = widen), the pulse in the following frames is one clock wider.
- R4: At an update with the synchronised direction bit high (1 = narrow), the pulse in the following frames is one clock narrower, as long as the width was above one.
- R5: Updates happen only at the last clock of a frame, after `UPD_N` frames that are not frozen have been counted.
- R6: While freeze is high at the end of a frame, that frame is not counted and the pulse width does not change.
- R7: Widening stops when the rise position reaches clock 0, so the width saturates at `PERIOD-1`.
- R8: Narrowing a one-clock pulse is a zero-duty collapse. From the next clock the output is low and the halt flag is high, and the positions return to the one-clock width.
- R9: While halted, an update with direction high keeps the engine halted with the output low. An update with direction low clears the flag, and the next frame carries a one-clock pulse.
- R10: While enable is low, the output, the halt flag, the frame position and the divider are all held at their reset values. After enable returns, the engine starts again as it does after reset.
- R11: The direction bit passes through two flip-flops and is only used at an update. Its value in frames that end without an update has no effect on the width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Engine enable; low holds the engine in its start state |
| dir_dn | input | 1 | Comparator direction: 0 widens, 1 narrows |
| freeze | input | 1 | Stops the update divider while high |
| pwm_out | output | 1 | Gate drive |
| zero_halt | output | 1 | High while the engine is halted after a zero-duty collapse |

## Verification
In the starting state, the fall event sits at the last clock of the frame, which is also the only clock in which an update can fire. A narrowing update from one-clock width therefore makes the collapse and the latch's own clear event fall in the same cycle. The bench provokes this coincidence on purpose: it sweeps the width all the way up and back down to collapse, and it also collapses directly from a freshly re-enabled engine. It judges the result from the count of high clocks in each frame, from the halt flag in the next frame, and from the output staying low in frames where narrowing continues. Frames with freeze set, and frames where the direction bit alternates, are interleaved so that the only frames that count are the ones that end with an update.

// File: rtl/pwm_step_pkg.sv
package pwm_step_pkg;

    localparam int unsigned DFLT_PERIOD = 50;
    localparam int unsigned DFLT_UPD_N  = 4;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_WIDEN,
        ACT_NARROW,
        ACT_COLLAPSE,
        ACT_RESUME,
        ACT_STAY
    } step_act_e;

    // Choose what an update instant does to the edge positions.
    function automatic step_act_e pick_act(
        input logic upd,
        input logic shrink,
        input logic halted,
        input logic rise_at_floor,
        input logic edges_adjacent
    );
        step_act_e a;
        if (!upd) begin
            a = ACT_HOLD;
        end else if (halted) begin
            a = shrink ? ACT_STAY : ACT_RESUME;
        end else if (!shrink) begin
            a = rise_at_floor ? ACT_HOLD : ACT_WIDEN;
        end else begin
            a = edges_adjacent ? ACT_COLLAPSE : ACT_NARROW;
        end
        return a;
    endfunction

endpackage

// File: rtl/pwm_step_sync.sv
module pwm_step_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwm_step_timer.sv
module pwm_step_timer #(
    parameter int unsigned PERIOD = 50,
    parameter int unsigned UPD_N  = 4,
    localparam int unsigned PW    = $clog2(PERIOD),
    localparam int unsigned DIV_W = (UPD_N > 1) ? $clog2(UPD_N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          freeze,
    output logic [PW-1:0] phase,
    output logic          upd
);
    localparam logic [PW-1:0]    PH_LAST  = PW'(PERIOD - 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(UPD_N - 1);

    logic [DIV_W-1:0] div_q;
    logic             frame_end;

    assign frame_end = en && (phase == PH_LAST);
    assign upd       = frame_end && !freeze && (div_q == DIV_LAST);

    always_ff @(posedge clk) begin
        if (rst || !en)              phase <= '0;
        else if (phase == PH_LAST)   phase <= '0;
        else                         phase <= phase + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_q <= '0;
        end else if (frame_end && !freeze) begin
            if (div_q == DIV_LAST) div_q <= '0;
            else                   div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_step_track.sv
module pwm_step_track
    import pwm_step_pkg::*;
#(
    parameter int unsigned PERIOD = 50,
    localparam int unsigned PW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          upd,
    input  logic          shrink,
    output logic [PW-1:0] rise_at,
    output logic [PW-1:0] fall_at,
    output logic          halted,
    output logic          collapse
);
    localparam logic [PW-1:0] RISE_INIT = PW'(PERIOD - 2);
    localparam logic [PW-1:0] FALL_INIT = PW'(PERIOD - 1);

    step_act_e act;

    always_comb begin
        act = pick_act(upd, shrink, halted, rise_at == '0,
                       fall_at == (rise_at + 1'b1));
    end

    assign collapse = (act == ACT_COLLAPSE);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            rise_at <= RISE_INIT;
            fall_at <= FALL_INIT;
            halted  <= 1'b0;
        end else begin
            unique case (act)
                ACT_WIDEN:    rise_at <= rise_at - 1'b1;
                ACT_NARROW:   fall_at <= fall_at - 1'b1;
                ACT_COLLAPSE: begin
                    rise_at <= RISE_INIT;
                    fall_at <= FALL_INIT;
                    halted  <= 1'b1;
                end
                ACT_RESUME:   halted <= 1'b0;
                default:      ;
            endcase
        end
    end
endmodule

// File: rtl/pwm_step_latch.sv
module pwm_step_latch #(
    parameter int unsigned PW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          kill,
    input  logic [PW-1:0] phase,
    input  logic [PW-1:0] rise_at,
    input  logic [PW-1:0] fall_at,
    output logic          pwm
);
    always_ff @(posedge clk) begin
        if (rst || !en || kill)    pwm <= 1'b0;
        else if (phase == rise_at) pwm <= 1'b1;
        else if (phase == fall_at) pwm <= 1'b0;
    end
endmodule

// File: rtl/pwm_step_gen.sv
module pwm_step_gen #(
    parameter int unsigned PERIOD = pwm_step_pkg::DFLT_PERIOD,
    parameter int unsigned UPD_N  = pwm_step_pkg::DFLT_UPD_N
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic dir_dn,
    input  logic freeze,
    output logic pwm_out,
    output logic zero_halt
);
    localparam int unsigned PW = $clog2(PERIOD);

    logic [PW-1:0] phase;
    logic [PW-1:0] rise_at;
    logic [PW-1:0] fall_at;
    logic          upd;
    logic          dir_sync;
    logic          collapse;

    pwm_step_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (dir_dn),
        .q   (dir_sync)
    );

    pwm_step_timer #(.PERIOD(PERIOD), .UPD_N(UPD_N)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .freeze (freeze),
        .phase  (phase),
        .upd    (upd)
    );

    pwm_step_track #(.PERIOD(PERIOD)) u_track (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .upd      (upd),
        .shrink   (dir_sync),
        .rise_at  (rise_at),
        .fall_at  (fall_at),
        .halted   (zero_halt),
        .collapse (collapse)
    );

    pwm_step_latch #(.PW(PW)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .kill    (collapse | zero_halt),
        .phase   (phase),
        .rise_at (rise_at),
        .fall_at (fall_at),
        .pwm     (pwm_out)
    );
endmodule

// File: rtl/pwm_step_gen_chk.sv
module pwm_step_gen_chk #(
    parameter int unsigned PW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          pwm,
    input logic          halted,
    input logic [PW-1:0] phase,
    input logic [PW-1:0] rise_at,
    input logic [PW-1:0] fall_at,
    input logic          upd,
    input logic          shrink
);
    logic [PW-1:0] span;
    assign span = fall_at - rise_at;

    p_frame_start_low_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == '0) |-> !pwm);

    p_edge_order_r1: assert property (@(posedge clk) disable iff (rst)
        rise_at < fall_at);

    p_widen_step_r3: assert property (@(posedge clk) disable iff (rst)
        (upd && !shrink && !halted && rise_at != '0) |=> span == PW'($past(span) + 1'b1));

    p_narrow_step_r4: assert property (@(posedge clk) disable iff (rst)
        (upd && shrink && !halted && $past(1'b1) && span != PW'(1)) |=> span == PW'($past(span) - 1'b1));

    p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
        (en && !upd) |=> ($stable(rise_at) && $stable(fall_at)));

    p_collapse_r8: assert property (@(posedge clk) disable iff (rst)
        (upd && shrink && !halted && span == PW'(1)) |=> (halted && !pwm));

    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        halted |-> !pwm);

    p_disable_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!pwm && !halted && phase == '0));
endmodule

bind pwm_step_gen pwm_step_gen_chk #(.PW(PW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .pwm     (pwm_out),
    .halted  (zero_halt),
    .phase   (phase),
    .rise_at (rise_at),
    .fall_at (fall_at),
    .upd     (upd),
    .shrink  (dir_sync)
);

// File: tb/pwm_step_gen_test.sv
module pwm_step_gen_test;
    localparam int P = 50;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst, en, dir_dn, freeze;
    logic pwm_out, zero_halt;

    int checks = 0;
    int fails  = 0;

    // bench model of the edge positions, kept per frame
    int ms, mr, mcnt;
    bit msd;

    pwm_step_gen #(.PERIOD(P), .UPD_N(N)) uut (
        .clk(clk), .rst(rst), .en(en), .dir_dn(dir_dn), .freeze(freeze),
        .pwm_out(pwm_out), .zero_halt(zero_halt)
    );

    always #2 clk = ~clk;

    task automatic check(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic model_init();
        ms = P - 2; mr = P - 1; mcnt = 0; msd = 0;
    endtask

    task automatic model_update(input bit d);
        if (msd) begin
            if (!d) msd = 0;
        end else if (!d) begin
            if (ms > 0) ms--;
        end else if (mr - ms == 1) begin
            msd = 1; ms = P - 2; mr = P - 1;
        end else begin
            mr--;
        end
    endtask

    // Called at the negedge inside the first clock of a frame.
    task automatic run_frame(input bit d, input bit f, input string rq);
        int hi = 0;
        int first = 0;
        int flag = 0;
        dir_dn = d;
        freeze = f;
        for (int p = 0; p < P; p++) begin
            if (p == 0) begin
                first = int'(pwm_out);
                flag  = int'(zero_halt);
            end
            if (pwm_out) hi++;
            @(negedge clk);
        end
        check("R1 frame start low", first, 0);
        check({rq, " width"}, hi, msd ? 0 : (mr - ms));
        check("R8 halt flag", flag, int'(msd));
        if (!f) begin
            if (mcnt == N - 1) begin
                mcnt = 0;
                model_update(d);
            end else begin
                mcnt++;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; en = 1'b1; dir_dn = 1'b0; freeze = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 reset pwm", int'(pwm_out), 0);
        check("R2 reset flag", int'(zero_halt), 0);
        rst = 1'b0;
        model_init();

        // R2 first frame one clock, then R3/R7 widen to saturation
        run_frame(1'b0, 1'b0, "R2");
        for (int j = 0; j < (P + 2) * N; j++) run_frame(1'b0, 1'b0, "R7");

        // R6 freeze while narrowing is requested
        for (int j = 0; j < 8; j++) run_frame(1'b1, 1'b1, "R6");

        // R4 narrow down to collapse, then R9 stay halted
        for (int j = 0; j < (P + 2) * N; j++) run_frame(1'b1, 1'b0, "R4");

        // R9 resume with direction low
        for (int j = 0; j < 3 * N; j++) run_frame(1'b0, 1'b0, "R9");

        // R11 direction toggling every frame; only update frames count
        for (int j = 0; j < 40; j++) run_frame(j[0], 1'b0, "R11");
        for (int j = 0; j < 40; j++) run_frame((j % 3) != 0, 1'b0, "R11");

        // R5 freeze on alternate frames while widening
        for (int j = 0; j < 32; j++) run_frame(1'b0, j[0], "R5");

        // R3 plain widening after the mixed patterns
        for (int j = 0; j < 4 * N; j++) run_frame(1'b0, 1'b0, "R3");

        // drive to collapse again so enable drop clears a halted engine
        for (int j = 0; j < (P + 2) * N; j++) begin
            if (msd) break;
            run_frame(1'b1, 1'b0, "R8");
        end
        run_frame(1'b1, 1'b0, "R8");
        check("R8 halted before disable", int'(zero_halt), 1);

        // R10 enable low holds everything quiet
        en = 1'b0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            check("R10 pwm off", int'(pwm_out), 0);
            check("R10 flag off", int'(zero_halt), 0);
        end
        en = 1'b1;
        model_init();
        for (int j = 0; j < 3 * N; j++) run_frame(1'b0, 1'b0, "R10");

        // narrow straight from a fresh one-clock width: collapse at frame end
        model_init();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int j = 0; j < 3 * N; j++) run_frame(1'b1, 1'b0, "R8");

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule